// File: doc/BRIEF.md
# ISA I/O Slave with DMA Request/Acknowledge Channels

This block sits between an 8-bit ISA-style I/O bus and the register logic of a peripheral controller. All bus inputs are brought into the internal clock domain. Each input passes through two flops, and a third flop detects its edges. A read or write strobe that targets the block captures the 11-bit address on its leading edge. The block then gives the internal logic a one-clock register access pulse. For a read it also drives the data bus until the strobe is released. A driven data bus is modelled as a data output with a separate output enable. While the enable is low the bus is high impedance.

A strobe counts as an ordinary I/O access only if the address-enable input is low and the address falls inside the block's window. The window test compares all eleven address bits. A strobe with address-enable high is a DMA access. It is steered to the one channel whose acknowledge is low, and the address plays no part. If more than one acknowledge is low, the strobe is dropped and a sticky conflict flag is set.

Each DMA channel raises its request output when internal logic gives it a request pulse. The request is held until the last byte of the transfer completes, or until the channel is disabled. When last-byte is flagged while the acknowledge is high, the request drops on the acknowledge's falling edge. When last-byte is flagged while the acknowledge is already held low (demand transfer), the request drops on the falling read strobe instead.

The bus sequencer has four states. BUS_IDLE goes to BUS_READ on a read fall to a valid target, to BUS_WRITE on a write fall to a valid target, and to BUS_SKIP on any other strobe fall. BUS_READ returns to BUS_IDLE on read rise. BUS_WRITE returns to BUS_IDLE on write rise and issues the write pulse at that point. BUS_SKIP returns to BUS_IDLE once both strobes are high.

Each channel also has four states. CH_IDLE goes to CH_REQ on a request pulse while enabled. CH_REQ goes to CH_LAST_ACK on last-byte while the acknowledge is high, or to CH_LAST_RD on last-byte while the acknowledge is low. CH_LAST_ACK goes to CH_IDLE on acknowledge fall. CH_LAST_RD goes to CH_IDLE on read fall, or to CH_LAST_ACK on acknowledge rise. From any state, disabling the channel returns it to CH_IDLE.

Top module: `isa_io_slave`

## Requirements
- R1: After reset, bus_doe, dma_req, reg_rd_en, reg_wr_en and dma_conflict are all 0.
- R2: With bus_aen low, the block responds only to addresses from BASE_ADDR (default 11'h3F0) through BASE_ADDR+NUM_REGS-1 (default 11'h3F7). An address that differs in any of the 11 bits, for example 11'h7F0, 11'h1F0, 11'h3EF or 11'h3F8, gives no register pulse and no bus drive.
- R3: With bus_aen high and every dma_ack_n bit high, no strobe gives a register pulse or bus drive, even to an address inside the window.
- R4: reg_addr carries the bus_addr value present at the strobe's falling edge. Address changes after that edge have no effect.
- R5: A read to a valid target gives one reg_rd_en pulse of one clock. bus_doe is high with bus_dout equal to reg_rdata by the 4th rising clock edge after bus_ior_n falls. bus_doe is low again by the 3rd rising edge after bus_ior_n rises.
- R6: A write to a valid target gives one reg_wr_en pulse of one clock, on the 3rd rising edge after bus_iow_n rises. The pulse carries the latched address and the bus_din value held while the strobe was low. bus_doe stays low.
- R7: With bus_aen high and exactly one dma_ack_n bit low, the access is taken whatever the address. reg_dma_sel is one-hot on that channel (bit i for channel i). For I/O accesses reg_dma_sel is 0.
- R8: With bus_aen high and two or more dma_ack_n bits low, the strobe gives no register pulse and no bus drive. dma_conflict goes high and stays high until reset.
- R9: A ch_req_pulse on an enabled channel raises its dma_req on the next rising edge. The request stays high through acknowledge activity until a last-byte clearing condition occurs.
- R10: After ch_last while the channel's acknowledge is high, dma_req stays high until the acknowledge falls. It then drops on the 3rd rising edge after that fall.
- R11: After ch_last while the acknowledge is already low, dma_req stays high while the acknowledge remains low. It drops on the 3rd rising edge after bus_ior_n falls.
- R12: Clearing ch_enable drops that channel's dma_req on the next rising edge. A ch_req_pulse on a disabled channel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ior_n | input | 1 | Host read strobe, active low |
| bus_iow_n | input | 1 | Host write strobe, active low |
| bus_aen | input | 1 | Address enable, high during DMA cycles |
| bus_addr | input | 11 | Host I/O address |
| bus_din | input | 8 | Data bus as seen by the block |
| bus_dout | output | 8 | Read data the block drives |
| bus_doe | output | 1 | Data bus output enable; low means high impedance |
| dma_ack_n | input | 3 | Per-channel DMA acknowledge, active low |
| dma_req | output | 3 | Per-channel DMA request, active high |
| ch_enable | input | 3 | Per-channel enable from internal logic |
| ch_req_pulse | input | 3 | Per-channel request pulse from internal logic |
| ch_last | input | 3 | Per-channel last-byte pulse from internal logic |
| reg_rd_en | output | 1 | One-clock register read pulse |
| reg_wr_en | output | 1 | One-clock register write pulse |
| reg_addr | output | 11 | Latched access address |
| reg_wdata | output | 8 | Latched write data |
| reg_dma_sel | output | 3 | One-hot channel of a DMA access, 0 for I/O |
| reg_rdata | input | 8 | Register read data from internal logic |
| dma_conflict | output | 1 | Sticky flag: multiple acknowledges seen on one access |

## Verification
A bus sequencer stuck outside BUS_IDLE shows up at the next strobe, which is silently dropped: the expected register pulse never arrives, and the scoreboard still holds the item when the run ends. A wrong transition into BUS_READ shows up within four clocks as a driven bus or a stray read pulse. A channel left in the wrong last-byte state shows up three clocks after the acknowledge or read fall as a request that fails to drop, or drops too early. A lost conflict flag shows up on the very next access.

// File: rtl/isa_slave_pkg.sv
package isa_slave_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_REQ,
        CH_LAST_ACK,
        CH_LAST_RD
    } ch_state_e;

endpackage

// File: rtl/isa_edge_sync.sv
module isa_edge_sync #(
    parameter int          W        = 1,
    parameter logic [W-1:0] IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= IDLE_VAL;
            sync_q <= IDLE_VAL;
            prev_q <= IDLE_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign fall  = prev_q & ~sync_q;
    assign rise  = ~prev_q & sync_q;

endmodule

// File: rtl/isa_addr_match.sv
module isa_addr_match #(
    parameter int                ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h3F0,
    parameter int                NUM_REGS  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W:0] LO = {1'b0, BASE_ADDR};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(NUM_REGS);

    logic [ADDR_W:0] addr_ext;

    always_comb begin
        addr_ext = {1'b0, addr};
        hit      = (addr_ext >= LO) && (addr_ext < HI);
    end

endmodule

// File: rtl/isa_dma_channel.sv
module isa_dma_channel
    import isa_slave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req_pulse,
    input  logic last_pulse,
    input  logic ack_lvl_n,
    input  logic ack_fall,
    input  logic ack_rise,
    input  logic rd_fall,
    output logic drq
);

    ch_state_e st_q;
    ch_state_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: begin
                if (enable && req_pulse) st_d = CH_REQ;
            end
            CH_REQ: begin
                if (last_pulse) st_d = ack_lvl_n ? CH_LAST_ACK : CH_LAST_RD;
            end
            CH_LAST_ACK: begin
                if (ack_fall) st_d = CH_IDLE;
            end
            CH_LAST_RD: begin
                if (rd_fall)       st_d = CH_IDLE;
                else if (ack_rise) st_d = CH_LAST_ACK;
            end
        endcase
        if (!enable) st_d = CH_IDLE;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drq <= 1'b0;
        else        drq <= (st_d != CH_IDLE);
    end

    AST_DRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !drq); // R12
    AST_DRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(enable && req_pulse)); // R9
    AST_DRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> $past(!enable || ack_fall || rd_fall)); // R10

endmodule

// File: rtl/isa_bus_fsm.sv
module isa_bus_fsm
    import isa_slave_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lvl,
    input  logic              wr_lvl,
    input  logic              rd_fall,
    input  logic              rd_rise,
    input  logic              wr_fall,
    input  logic              wr_rise,
    input  logic              aen_lvl,
    input  logic [NUM_CH-1:0] ack_lvl_n,
    input  logic              addr_hit,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_dma_sel,
    output logic              dma_conflict,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe
);

    localparam int CW = $clog2(NUM_CH + 1) + 1;

    bus_state_e        st_q, st_d;
    logic [NUM_CH-1:0] ack_low;
    logic [CW-1:0]     ack_cnt;
    logic              dma_ok, dma_clash, target_ok;

    logic              rd_en_d, wr_en_d, conflict_d, oe_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d, rdata_d;
    logic [NUM_CH-1:0] sel_d;

    always_comb begin
        ack_low = ~ack_lvl_n;
        ack_cnt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            ack_cnt = ack_cnt + CW'(ack_low[i]);
        end
        dma_ok    = aen_lvl && (ack_cnt == CW'(1));
        dma_clash = aen_lvl && (ack_cnt > CW'(1));
        target_ok = dma_ok || (!aen_lvl && addr_hit);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // next state and next outputs
    always_comb begin
        st_d       = st_q;
        rd_en_d    = 1'b0;
        wr_en_d    = 1'b0;
        oe_d       = 1'b0;
        addr_d     = reg_addr;
        wdata_d    = reg_wdata;
        rdata_d    = bus_rdata;
        sel_d      = reg_dma_sel;
        conflict_d = dma_conflict;
        unique case (st_q)
            BUS_IDLE: begin
                if (rd_fall || wr_fall) begin
                    addr_d     = bus_addr;
                    sel_d      = dma_ok ? ack_low : '0;
                    conflict_d = dma_conflict || dma_clash;
                    if (!target_ok) begin
                        st_d = BUS_SKIP;
                    end else if (rd_fall) begin
                        st_d    = BUS_READ;
                        rd_en_d = 1'b1;
                    end else begin
                        st_d = BUS_WRITE;
                    end
                end
            end
            BUS_READ: begin
                if (reg_rd_en) rdata_d = reg_rdata;
                if (rd_rise) st_d = BUS_IDLE;
                else         oe_d = 1'b1;
            end
            BUS_WRITE: begin
                if (wr_rise) begin
                    st_d    = BUS_IDLE;
                    wr_en_d = 1'b1;
                end else begin
                    wdata_d = bus_wdata;
                end
            end
            BUS_SKIP: begin
                if (rd_lvl && wr_lvl) st_d = BUS_IDLE;
            end
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rd_en    <= 1'b0;
            reg_wr_en    <= 1'b0;
            reg_addr     <= '0;
            reg_wdata    <= '0;
            reg_dma_sel  <= '0;
            dma_conflict <= 1'b0;
            bus_rdata    <= '0;
            bus_oe       <= 1'b0;
        end else begin
            reg_rd_en    <= rd_en_d;
            reg_wr_en    <= wr_en_d;
            reg_addr     <= addr_d;
            reg_wdata    <= wdata_d;
            reg_dma_sel  <= sel_d;
            dma_conflict <= conflict_d;
            bus_rdata    <= rdata_d;
            bus_oe       <= oe_d;
        end
    end

    AST_RD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en); // R5
    AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R6
    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en)); // R6
    AST_OE_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !reg_wr_en); // R5
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_dma_sel)); // R7
    AST_CONFLICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_conflict |=> dma_conflict); // R8

endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
    import isa_slave_pkg::*;
#(
    parameter int                ADDR_W    = 11,
    parameter int                DATA_W    = 8,
    parameter int                NUM_CH    = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h3F0,
    parameter int                NUM_REGS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ior_n,
    input  logic              bus_iow_n,
    input  logic              bus_aen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [NUM_CH-1:0] dma_ack_n,
    output logic [NUM_CH-1:0] dma_req,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_req_pulse,
    input  logic [NUM_CH-1:0] ch_last,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [NUM_CH-1:0] reg_dma_sel,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              dma_conflict
);

    logic [1:0]        stb_lvl, stb_fall, stb_rise;
    logic [NUM_CH-1:0] ack_lvl_n, ack_fall, ack_rise;
    logic              aen_meta_q, aen_q;
    logic              addr_hit;

    // bit 0: read strobe, bit 1: write strobe
    isa_edge_sync #(.W(2), .IDLE_VAL(2'b11)) u_stb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_iow_n, bus_ior_n}),
        .level    (stb_lvl),
        .fall     (stb_fall),
        .rise     (stb_rise)
    );

    isa_edge_sync #(.W(NUM_CH), .IDLE_VAL({NUM_CH{1'b1}})) u_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dma_ack_n),
        .level    (ack_lvl_n),
        .fall     (ack_fall),
        .rise     (ack_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aen_meta_q <= 1'b0;
            aen_q      <= 1'b0;
        end else begin
            aen_meta_q <= bus_aen;
            aen_q      <= aen_meta_q;
        end
    end

    isa_addr_match #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS)
    ) u_match (
        .addr (bus_addr),
        .hit  (addr_hit)
    );

    isa_bus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_lvl       (stb_lvl[0]),
        .wr_lvl       (stb_lvl[1]),
        .rd_fall      (stb_fall[0]),
        .rd_rise      (stb_rise[0]),
        .wr_fall      (stb_fall[1]),
        .wr_rise      (stb_rise[1]),
        .aen_lvl      (aen_q),
        .ack_lvl_n    (ack_lvl_n),
        .addr_hit     (addr_hit),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_din),
        .reg_rdata    (reg_rdata),
        .reg_rd_en    (reg_rd_en),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_dma_sel  (reg_dma_sel),
        .dma_conflict (dma_conflict),
        .bus_rdata    (bus_dout),
        .bus_oe       (bus_doe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        isa_dma_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (ch_enable[c]),
            .req_pulse  (ch_req_pulse[c]),
            .last_pulse (ch_last[c]),
            .ack_lvl_n  (ack_lvl_n[c]),
            .ack_fall   (ack_fall[c]),
            .ack_rise   (ack_rise[c]),
            .rd_fall    (stb_fall[0]),
            .drq        (dma_req[c])
        );
    end

endmodule

// File: tb/isa_io_slave_tb.sv
module isa_io_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ior_n = 1'b1, bus_iow_n = 1'b1, bus_aen = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic [2:0]  dma_ack_n = 3'b111;
    logic [2:0]  dma_req;
    logic [2:0]  ch_enable = '0, ch_req_pulse = '0, ch_last = '0;
    logic        reg_rd_en, reg_wr_en, dma_conflict;
    logic [10:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [2:0]  reg_dma_sel;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed {
        logic        is_wr;
        logic [10:0] addr;
        logic [7:0]  data;
        logic [2:0]  sel;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rd_model(logic [10:0] a, logic [2:0] s);
        return a[7:0] ^ 8'hA5 ^ {5'b0, s};
    endfunction

    assign reg_rdata = rd_model(reg_addr, reg_dma_sel);

    isa_io_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
        .bus_aen(bus_aen), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .dma_ack_n(dma_ack_n),
        .dma_req(dma_req), .ch_enable(ch_enable), .ch_req_pulse(ch_req_pulse),
        .ch_last(ch_last), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_dma_sel(reg_dma_sel),
        .reg_rdata(reg_rdata), .dma_conflict(dma_conflict)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every register pulse
    always @(negedge clk) begin
        if (rst_n && (reg_rd_en || reg_wr_en)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R3/R8 unexpected pulse", {reg_wr_en, reg_addr}, 0);
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                check(reg_wr_en == e.is_wr && reg_rd_en != e.is_wr,
                      "R5/R6 pulse kind", {reg_wr_en, reg_rd_en}, {e.is_wr, !e.is_wr});
                check(reg_addr == e.addr, "R4 latched address", reg_addr, e.addr);
                check(reg_dma_sel == e.sel, "R7 channel select", reg_dma_sel, e.sel);
                if (e.is_wr)
                    check(reg_wdata == e.data, "R6 write data", reg_wdata, e.data);
            end
        end
    end

    task automatic bus_cycle(input bit is_wr, input logic [10:0] addr,
                             input logic [7:0] data, input logic aen,
                             input logic [2:0] acks, input bit hit,
                             input logic [2:0] sel, input string req);
        @(negedge clk);
        bus_aen = aen; dma_ack_n = acks; bus_addr = addr; bus_din = data;
        repeat (3) @(negedge clk);
        if (hit) exp_q.push_back('{is_wr, addr, data, sel});
        if (is_wr) bus_iow_n = 1'b0; else bus_ior_n = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        if (!is_wr) begin
            check(bus_doe == hit, req, bus_doe, hit);
            if (hit) check(bus_dout == rd_model(addr, sel), req, bus_dout,
                           rd_model(addr, sel));
        end else begin
            check(bus_doe == 1'b0, "R6 no drive on write", bus_doe, 0);
        end
        @(negedge clk);
        bus_addr = ~addr; // R4: address moves after the leading edge
        repeat (2) @(negedge clk);
        bus_ior_n = 1'b1; bus_iow_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        if (!is_wr) check(bus_doe == 1'b0, "R5 release", bus_doe, 0);
        repeat (2) @(negedge clk);
        bus_aen = 1'b0; dma_ack_n = 3'b111; bus_din = ~data;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R5/R6 missing pulses", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(bus_doe == 0 && dma_req == 0 && !reg_rd_en && !reg_wr_en && !dma_conflict,
              "R1 reset state", {bus_doe, dma_req, dma_conflict}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6 / R4 / R5 main I/O path
        bus_cycle(1, 11'h3F2, 8'h3C, 0, 3'b111, 1, 3'b000, "R6 write");
        bus_cycle(1, 11'h3F7, 8'hC3, 0, 3'b111, 1, 3'b000, "R6 write top");
        bus_cycle(0, 11'h3F0, 8'h00, 0, 3'b111, 1, 3'b000, "R5 read base");
        bus_cycle(0, 11'h3F7, 8'h00, 0, 3'b111, 1, 3'b000, "R5 read top");
        // R2 full decode
        bus_cycle(0, 11'h7F0, 8'h00, 0, 3'b111, 0, 3'b000, "R2 bit10 alias");
        bus_cycle(0, 11'h3EF, 8'h00, 0, 3'b111, 0, 3'b000, "R2 below window");
        bus_cycle(1, 11'h3F8, 8'h11, 0, 3'b111, 0, 3'b000, "R2 above window");
        bus_cycle(1, 11'h1F0, 8'h22, 0, 3'b111, 0, 3'b000, "R2 bit9 alias");
        // R3 AEN blocks decode
        bus_cycle(0, 11'h3F1, 8'h00, 1, 3'b111, 0, 3'b000, "R3 aen read");
        bus_cycle(1, 11'h3F1, 8'h33, 1, 3'b111, 0, 3'b000, "R3 aen write");
        // R7 DMA steering
        bus_cycle(0, 11'h123, 8'h00, 1, 3'b101, 1, 3'b010, "R7 dma read ch1");
        bus_cycle(1, 11'h0AA, 8'h5E, 1, 3'b011, 1, 3'b100, "R7 dma write ch2");
        // R8 conflict
        check(dma_conflict == 0, "R8 no conflict yet", dma_conflict, 0);
        bus_cycle(0, 11'h3F3, 8'h00, 1, 3'b100, 0, 3'b000, "R8 conflict read");
        check(dma_conflict == 1, "R8 conflict set", dma_conflict, 1);
        bus_cycle(1, 11'h3F4, 8'h44, 0, 3'b111, 1, 3'b000, "R8 io after conflict");
        check(dma_conflict == 1, "R8 conflict sticky", dma_conflict, 1);

        // R9 / R10 channel 0
        @(negedge clk); ch_enable = 3'b111; ch_req_pulse = 3'b001;
        @(negedge clk); ch_req_pulse = 3'b000;
        check(dma_req == 3'b001, "R9 request raised", dma_req, 3'b001);
        dma_ack_n = 3'b110; repeat (4) @(negedge clk);
        dma_ack_n = 3'b111; repeat (4) @(negedge clk);
        check(dma_req[0] == 1, "R9 held without last", dma_req, 3'b001);
        ch_last = 3'b001; @(negedge clk); ch_last = 3'b000;
        repeat (3) @(negedge clk);
        check(dma_req[0] == 1, "R10 held until ack", dma_req, 3'b001);
        dma_ack_n = 3'b110;
        repeat (2) @(posedge clk); #1;
        check(dma_req[0] == 1, "R10 not early", dma_req, 3'b001);
        @(posedge clk); #1;
        check(dma_req[0] == 0, "R10 drop on ack fall", dma_req, 3'b000);
        @(negedge clk); dma_ack_n = 3'b111; repeat (4) @(negedge clk);

        // R11 demand mode on channel 1
        ch_req_pulse = 3'b010; @(negedge clk); ch_req_pulse = 3'b000;
        dma_ack_n = 3'b101; repeat (4) @(negedge clk);
        ch_last = 3'b010; @(negedge clk); ch_last = 3'b000;
        repeat (6) @(negedge clk);
        check(dma_req[1] == 1, "R11 held while ack low", dma_req, 3'b010);
        bus_aen = 1'b1; bus_addr = 11'h055; repeat (3) @(negedge clk);
        exp_q.push_back('{1'b0, 11'h055, 8'h00, 3'b010});
        bus_ior_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        check(dma_req[1] == 1, "R11 not early", dma_req, 3'b010);
        @(posedge clk); #1;
        check(dma_req[1] == 0, "R11 drop on read fall", dma_req, 3'b000);
        @(posedge clk); #1;
        check(bus_doe == 1 && bus_dout == rd_model(11'h055, 3'b010), "R7 dma read data",
              bus_dout, rd_model(11'h055, 3'b010));
        @(negedge clk); bus_ior_n = 1'b1; repeat (4) @(negedge clk);
        bus_aen = 1'b0; dma_ack_n = 3'b111; repeat (4) @(negedge clk);

        // R12 disable
        ch_req_pulse = 3'b100; @(negedge clk); ch_req_pulse = 3'b000;
        check(dma_req[2] == 1, "R12 request on", dma_req, 3'b100);
        ch_enable = 3'b011; @(negedge clk);
        check(dma_req[2] == 0, "R12 disable clears", dma_req, 3'b000);
        ch_req_pulse = 3'b100; @(negedge clk); ch_req_pulse = 3'b000;
        repeat (3) @(negedge clk);
        check(dma_req == 3'b000, "R12 pulse ignored when disabled", dma_req, 3'b000);

        // R1 / R8 reset clears the flag
        rst_n = 1'b0; repeat (2) @(negedge clk);
        check(dma_conflict == 0 && bus_doe == 0, "R1 re-reset", dma_conflict, 0);
        rst_n = 1'b1; repeat (3) @(negedge clk);

        finish_run();
    end

endmodule